// File: doc/BRIEF.md
# Dual-Pair Bank Ownership Controller

This block arbitrates four external memory banks between a pixel processing engine and a host processor. The banks form two pairs. At any moment one pair belongs to the engine: the engine writes the processed image into the first bank of the pair and the histogram bins into the second. The other pair belongs to the host, which reads the results of the previous frame from it. Each bank holds 2 Mbyte as 32-bit words. A frame uses 1 Mbyte of image data and 256 Kbyte of histogram data, so one bank of each kind holds a whole frame.

Requests from both sides are routed to the right physical bank in the same cycle. A request for a bank that the other side owns is refused. The pairs swap only at a frame boundary, and only when both sides agree. The engine signals that its frame is complete. The host signals that it has finished with its pair. The engine is held not-ready from its frame-done until the swap, so it cannot start the next frame in a pair that the host is still reading. Bank timing and the memory protocol are the concern of the memory ports outside this block.

Top module: `bank_owner_ctrl`

## Requirements
- R1: After reset the block is in phase A, `eng_rdy_o` is 1, no bank is enabled, and the host counts as already released, so a single `eng_frame_done_i` pulse swaps the pairs at that clock edge.
- R2: In phase A an engine request with `eng_sel_hist_i`=0 enables and write-enables bank 0, and one with `eng_sel_hist_i`=1 enables and write-enables bank 1, carrying `eng_addr_i` and `eng_wdata_i` to that bank.
- R3: In phase B the engine's image writes go to bank 2 and its histogram writes go to bank 3.
- R4: A host request to a bank of the host's own pair (banks 2 and 3 in phase A, banks 0 and 1 in phase B) enables that bank with write-enable 0 and `host_addr_i`. In the same cycle `host_rdata_o` shows that bank's read data and `host_err_o` is 0.
- R5: A host request to a bank of the engine's pair sets `host_err_o`, enables no bank for reading, and returns `host_rdata_o`=0.
- R6: From the edge that samples `eng_frame_done_i` until the swap, `eng_rdy_o` is 0 and engine requests write no bank.
- R7: Frame-done without host release does not change the phase, and host release without frame-done does not change it either.
- R8: The phase toggles at the clock edge where the later of the two conditions (frame-done, host release) is sampled. Pulses in the same cycle also swap at once. A swap clears both conditions and brings `eng_rdy_o` back to 1.
- R9: No bank is ever write-enabled for the engine and read-enabled for the host in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eng_req_i | input | 1 | Engine write request |
| eng_sel_hist_i | input | 1 | 0 selects the image bank, 1 selects the histogram bank |
| eng_addr_i | input | ADDR_W | Engine word address within the bank |
| eng_wdata_i | input | DATA_W | Engine write data |
| eng_frame_done_i | input | 1 | Pulse: engine finished the frame |
| eng_rdy_o | output | 1 | Engine may issue writes |
| host_req_i | input | 1 | Host read request |
| host_bank_i | input | 2 | Physical bank the host addresses |
| host_addr_i | input | ADDR_W | Host word address within the bank |
| host_done_i | input | 1 | Pulse: host released its pair |
| host_rdata_o | output | DATA_W | Read data from the addressed bank, 0 on refusal |
| host_err_o | output | 1 | Host request refused |
| mem_en_o | output | 4 | Per-bank enable |
| mem_we_o | output | 4 | Per-bank write enable |
| mem_addr_o | output | 4*ADDR_W | Per-bank address, bank b at bits [b*ADDR_W +: ADDR_W] |
| mem_wdata_o | output | 4*DATA_W | Per-bank write data |
| mem_rdata_i | input | 4*DATA_W | Per-bank read data |

## Verification
Two overlaps can fall in the same cycle here. An engine write and a host read can arrive together, and the frame-done and host-release pulses can arrive together. The bench drives an engine write and a host read at once, both to legal banks and with the host aimed at the engine's bank. It then compares the per-bank enables, write enables, addresses and the error flag against the ownership rule for the phase. For the pulses, it asserts both in one cycle and checks that the very next routing decision already uses the other pair and that the engine stays ready.

// File: rtl/bank_own_pkg.sv
package bank_own_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;

  // physical bank = {pair, role}; engine pair equals phase
  function automatic logic [NUM_BANKS-1:0] eng_pair_mask(phase_e ph);
    return (ph == PH_A) ? 4'b0011 : 4'b1100;
  endfunction
endpackage

// File: rtl/bank_phase_fsm.sv
module bank_phase_fsm
  import bank_own_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   frame_done_i,
  input  logic   host_done_i,
  output phase_e phase_o,
  output logic   eng_hold_o
);
  phase_e phase_q;
  logic   eng_done_q, host_done_q;
  logic   eng_pend, host_pend, swap;

  assign eng_pend  = eng_done_q | frame_done_i;
  assign host_pend = host_done_q | host_done_i;
  assign swap      = eng_pend & host_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_A;
      eng_done_q  <= 1'b0;
      host_done_q <= 1'b1;  // host owns nothing worth keeping at start
    end else if (swap) begin
      phase_q     <= (phase_q == PH_A) ? PH_B : PH_A;
      eng_done_q  <= 1'b0;
      host_done_q <= 1'b0;
    end else begin
      eng_done_q  <= eng_pend;
      host_done_q <= host_pend;
    end
  end

  assign phase_o    = phase_q;
  assign eng_hold_o = eng_done_q;
endmodule

// File: rtl/bank_eng_router.sv
module bank_eng_router
  import bank_own_pkg::*;
(
  input  phase_e               phase_i,
  input  logic                 req_i,
  input  logic                 hold_i,
  input  logic                 sel_hist_i,
  output logic [NUM_BANKS-1:0] bank_we_o
);
  logic [BANK_W-1:0] bank_idx;
  assign bank_idx = {logic'(phase_i), sel_hist_i};

  always_comb begin
    bank_we_o = '0;
    if (req_i && !hold_i) bank_we_o[bank_idx] = 1'b1;
  end
endmodule

// File: rtl/bank_host_router.sv
module bank_host_router
  import bank_own_pkg::*;
(
  input  phase_e               phase_i,
  input  logic                 req_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] bank_re_o,
  output logic                 ok_o,
  output logic                 err_o
);
  logic owned;
  // host holds the pair the engine does not
  assign owned = (bank_i[BANK_W-1] != logic'(phase_i));
  assign ok_o  = req_i & owned;
  assign err_o = req_i & ~owned;

  always_comb begin
    bank_re_o = '0;
    if (ok_o) bank_re_o[bank_i] = 1'b1;
  end
endmodule

// File: rtl/bank_owner_ctrl.sv
module bank_owner_ctrl
  import bank_own_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        eng_req_i,
  input  logic                        eng_sel_hist_i,
  input  logic [ADDR_W-1:0]           eng_addr_i,
  input  logic [DATA_W-1:0]           eng_wdata_i,
  input  logic                        eng_frame_done_i,
  output logic                        eng_rdy_o,
  input  logic                        host_req_i,
  input  logic [1:0]                  host_bank_i,
  input  logic [ADDR_W-1:0]           host_addr_i,
  input  logic                        host_done_i,
  output logic [DATA_W-1:0]           host_rdata_o,
  output logic                        host_err_o,
  output logic [3:0]                  mem_en_o,
  output logic [3:0]                  mem_we_o,
  output logic [4*ADDR_W-1:0]         mem_addr_o,
  output logic [4*DATA_W-1:0]         mem_wdata_o,
  input  logic [4*DATA_W-1:0]         mem_rdata_i
);
  phase_e               phase_q;
  logic                 eng_hold;
  logic [NUM_BANKS-1:0] eng_we, host_re;
  logic                 host_ok;

  bank_phase_fsm u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_done_i(eng_frame_done_i),
    .host_done_i (host_done_i),
    .phase_o     (phase_q),
    .eng_hold_o  (eng_hold)
  );

  bank_eng_router u_eng (
    .phase_i   (phase_q),
    .req_i     (eng_req_i),
    .hold_i    (eng_hold),
    .sel_hist_i(eng_sel_hist_i),
    .bank_we_o (eng_we)
  );

  bank_host_router u_host (
    .phase_i  (phase_q),
    .req_i    (host_req_i),
    .bank_i   (host_bank_i),
    .bank_re_o(host_re),
    .ok_o     (host_ok),
    .err_o    (host_err_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign mem_en_o[b] = eng_we[b] | host_re[b];
    assign mem_we_o[b] = eng_we[b];
    assign mem_addr_o[b*ADDR_W +: ADDR_W] =
      eng_we[b] ? eng_addr_i : (host_re[b] ? host_addr_i : '0);
    assign mem_wdata_o[b*DATA_W +: DATA_W] = eng_we[b] ? eng_wdata_i : '0;
  end

  assign host_rdata_o = host_ok ? mem_rdata_i[host_bank_i*DATA_W +: DATA_W] : '0;
  assign eng_rdy_o    = ~eng_hold;
endmodule

// File: rtl/bank_owner_ctrl_chk.sv
module bank_owner_ctrl_chk
  import bank_own_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input phase_e            phase_q,
  input logic              eng_rdy_o,
  input logic              eng_frame_done_i,
  input logic              host_err_o,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic [3:0]        mem_en_o,
  input logic [3:0]        mem_we_o
);
  logic [3:0] eng_mask, rd_en;
  assign eng_mask = eng_pair_mask(phase_q);
  assign rd_en    = mem_en_o & ~mem_we_o;

  assert_write_in_eng_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o & ~eng_mask) == 4'b0000);

  assert_no_shared_bank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en & eng_mask) == 4'b0000);

  assert_refusal_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_err_o |-> (host_rdata_o == '0 && rd_en == 4'b0000));

  assert_hold_blocks_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_rdy_o |-> mem_we_o == 4'b0000);

  assert_swap_needs_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> $past(!eng_rdy_o || eng_frame_done_i));

  assert_ready_after_swap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> eng_rdy_o);
endmodule

bind bank_owner_ctrl bank_owner_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .phase_q         (phase_q),
  .eng_rdy_o       (eng_rdy_o),
  .eng_frame_done_i(eng_frame_done_i),
  .host_err_o      (host_err_o),
  .host_rdata_o    (host_rdata_o),
  .mem_en_o        (mem_en_o),
  .mem_we_o        (mem_we_o)
);

// File: tb/bank_owner_ctrl_tb_top.sv
module bank_owner_ctrl_tb_top;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] EA = 19'h1_2345;
  localparam logic [ADDR_W-1:0] HA = 19'h0_4567;
  localparam logic [DATA_W-1:0] WD = 32'hFACE_0001;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic eng_req_i = 0, eng_sel_hist_i = 0, eng_frame_done_i = 0, eng_rdy_o;
  logic [ADDR_W-1:0] eng_addr_i = EA, host_addr_i = HA;
  logic [DATA_W-1:0] eng_wdata_i = WD, host_rdata_o;
  logic host_req_i = 0, host_done_i = 0, host_err_o;
  logic [1:0] host_bank_i = 0;
  logic [3:0] mem_en_o, mem_we_o;
  logic [4*ADDR_W-1:0] mem_addr_o;
  logic [4*DATA_W-1:0] mem_wdata_o, mem_rdata_i;
  int errors = 0, checks = 0;

  // each bank returns a recognisable word
  for (genvar b = 0; b < 4; b++) begin : g_rd
    assign mem_rdata_i[b*DATA_W +: DATA_W] = 32'hC0DE_0000 | b;
  end

  always #2.5 clk_i = ~clk_i;

  bank_owner_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

  // {eng_req, sel_hist, host_req, host_bank[1:0], exp_en[3:0], exp_we[3:0], exp_err}
  localparam int NV = 9;
  localparam logic [13:0] VEC_A [NV] = '{
    {1'b1,1'b0,1'b0,2'd0,4'b0001,4'b0001,1'b0},  // R2 image
    {1'b1,1'b1,1'b0,2'd0,4'b0010,4'b0010,1'b0},  // R2 histogram
    {1'b0,1'b0,1'b1,2'd2,4'b0100,4'b0000,1'b0},  // R4
    {1'b0,1'b0,1'b1,2'd3,4'b1000,4'b0000,1'b0},  // R4
    {1'b0,1'b0,1'b1,2'd0,4'b0000,4'b0000,1'b1},  // R5
    {1'b0,1'b0,1'b1,2'd1,4'b0000,4'b0000,1'b1},  // R5
    {1'b1,1'b0,1'b1,2'd3,4'b1001,4'b0001,1'b0},  // R9 both sides
    {1'b1,1'b1,1'b1,2'd1,4'b0010,4'b0010,1'b1},  // R5/R9 collision
    {1'b0,1'b0,1'b0,2'd0,4'b0000,4'b0000,1'b0}   // idle
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns later (all paths combinational)
  task automatic route(input logic er, input logic sh, input logic hr, input logic [1:0] hb,
                       input logic [3:0] en, input logic [3:0] we, input logic err,
                       input string req);
    logic [DATA_W-1:0] exp_rd;
    @(negedge clk_i);
    eng_req_i = er; eng_sel_hist_i = sh; host_req_i = hr; host_bank_i = hb;
    #1;
    chk(mem_en_o == en, req, "mem_en", 64'(mem_en_o), 64'(en));
    chk(mem_we_o == we, req, "mem_we", 64'(mem_we_o), 64'(we));
    chk(host_err_o == err, req, "host_err", 64'(host_err_o), 64'(err));
    exp_rd = (hr && !err) ? (32'hC0DE_0000 | 32'(hb)) : '0;
    chk(host_rdata_o == exp_rd, req, "host_rdata", 64'(host_rdata_o), 64'(exp_rd));
    for (int b = 0; b < 4; b++) begin
      if (en[b]) chk(mem_addr_o[b*ADDR_W +: ADDR_W] == (we[b] ? EA : HA), req, "mem_addr",
                     64'(mem_addr_o[b*ADDR_W +: ADDR_W]), 64'(we[b] ? EA : HA));
      if (we[b]) chk(mem_wdata_o[b*DATA_W +: DATA_W] == WD, req, "mem_wdata",
                     64'(mem_wdata_o[b*DATA_W +: DATA_W]), 64'(WD));
    end
    eng_req_i = 0; host_req_i = 0;
  endtask

  task automatic pulse(input logic fd, input logic hd);
    @(negedge clk_i);
    eng_frame_done_i = fd; host_done_i = hd;
    @(negedge clk_i);
    eng_frame_done_i = 0; host_done_i = 0;
  endtask

  task automatic rdy_is(input logic exp, input string req);
    #1 chk(eng_rdy_o == exp, req, "eng_rdy", 64'(eng_rdy_o), 64'(exp));
  endtask

  initial begin : watchdog
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk(mem_en_o == 4'b0000, "R1", "mem_en in reset", 64'(mem_en_o), 64'h0);
    chk(eng_rdy_o == 1'b1, "R1", "eng_rdy in reset", 64'(eng_rdy_o), 64'h1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // phase A routing table
    for (int i = 0; i < NV; i++)
      route(VEC_A[i][13], VEC_A[i][12], VEC_A[i][11], VEC_A[i][10:9],
            VEC_A[i][8:5], VEC_A[i][4:1], VEC_A[i][0], "R2/R4/R5/R9 phase A");

    // R1: host counts as released after reset, one frame-done swaps
    pulse(1, 0);
    rdy_is(1'b1, "R1");
    route(1, 0, 0, 0, 4'b0100, 4'b0100, 0, "R1 swap to B");
    route(1, 1, 0, 0, 4'b1000, 4'b1000, 0, "R3 histogram");
    route(0, 0, 1, 2'd1, 4'b0010, 4'b0000, 0, "R4 phase B");
    route(0, 0, 1, 2'd2, 4'b0000, 4'b0000, 1, "R5 phase B");

    // R6/R7: frame-done without host release holds the engine
    pulse(1, 0);
    rdy_is(1'b0, "R6");
    route(1, 0, 0, 0, 4'b0000, 4'b0000, 0, "R6 write blocked");
    repeat (4) @(negedge clk_i);
    route(0, 0, 1, 2'd0, 4'b0001, 4'b0000, 0, "R7 still B");
    rdy_is(1'b0, "R7");
    pulse(0, 1);
    rdy_is(1'b1, "R8");
    route(1, 0, 0, 0, 4'b0001, 4'b0001, 0, "R8 swap to A");

    // R7: host release alone does not swap
    pulse(0, 1);
    repeat (3) @(negedge clk_i);
    route(1, 1, 0, 0, 4'b0010, 4'b0010, 0, "R7 host only");
    rdy_is(1'b1, "R7");
    pulse(1, 0);
    route(1, 1, 0, 0, 4'b1000, 4'b1000, 0, "R8 later frame-done swaps");

    // R8: both pulses in one cycle
    pulse(1, 1);
    rdy_is(1'b1, "R8");
    route(1, 0, 1, 2'd3, 4'b1001, 4'b0001, 0, "R8 same-cycle swap");

    // R8: swap cleared host release, frame-done alone must hold
    pulse(1, 0);
    rdy_is(1'b0, "R8");
    route(1, 0, 0, 0, 4'b0000, 4'b0000, 0, "R8 release cleared");

    // R1: reset mid-hold returns to phase A, ready
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rdy_is(1'b1, "R1");
    route(1, 0, 0, 0, 4'b0001, 4'b0001, 0, "R1 phase A after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule